// File: doc/BRIEF.md
# SDRAM Command Spacing Checker

This block watches a stream of already decoded SDRAM commands and measures, in clock cycles, the gap between each command and the earlier commands that constrain it. It checks four rules. A write must not come too soon after a read, because the data bus needs time to turn around. A column access must not come too soon after its bank was opened. A bank that is closing itself after an auto-precharge access must not receive a command during that lockout. A mode register load must not come too soon after a precharge. Any command that breaks a rule is reported one clock later on a single-cycle violation pulse, together with a rule code and the bank the command named.

Spacing limits come from configuration inputs rather than fixed constants: CAS latency, burst length, activate-to-column delay, precharge time and write recovery. The turnaround limit is CL plus half the burst length, plus one more cycle when the fast-grade input is set. Each bank has its own pair of down-counters, for activate-to-column and for lockout. A shared pair covers bus turnaround and precharge-to-mode-load. A counter at zero means its window has closed. Each new command of the kind that opens a window reloads the counter from that command's cycle.

The command input is a valid/ready stream. The checker never applies back-pressure: `cmd_ready` is low during reset and high from the first clock after reset. A command is taken in every cycle where `cmd_valid` is high. Counters are updated by every accepted command, including a command that is itself flagged.

Top module: `sdr_cmd_spacing_chk`

## Requirements
- R1: While `rst_n` is low, `viol` is 0, `viol_code` is 0 and `cmd_ready` is 0.
- R2: From the second clock after reset release, `cmd_ready` stays 1. A cycle with `cmd_valid` low, or with opcode NOP (`cmd_op` = 0), never raises `viol`. Opcodes are: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all, 6 refresh, 7 mode register load.
- R3: A write accepted k cycles after the most recent read to any bank (with or without auto-precharge) is flagged with code 3 when k < CL + BL/2 + F. Here CL = `cfg_cl`, BL/2 is 1, 2 or 4 for `cfg_bl_sel` = 0, 1 or 2/3, and F = `cfg_fast`.
- R4: With `cfg_fast` = 1, a write exactly CL + BL/2 cycles after a read is flagged. With `cfg_fast` = 0 the same write is accepted.
- R5: A read or write to bank b accepted k cycles after the most recent activate to bank b is flagged with code 2 when k < `cfg_trcd`.
- R6: After a read with auto-precharge (`cmd_ap` = 1) to bank b, an activate, read, write or precharge to bank b accepted k cycles later is flagged with code 1 when k < BL/2 + tRP.
- R7: After a write with auto-precharge to bank b, the same commands to bank b are flagged with code 1 when k < BL/2 + 1 + tWR + tRP.
- R8: Precharge-all, refresh and mode register load are flagged with code 1 while any bank is inside its auto-precharge lockout.
- R9: A mode register load accepted k cycles after the most recent precharge or precharge-all is flagged with code 4 when k < `cfg_trp`.
- R10: Every window is measured from the latest command that opens it, and a newer such command restarts it. Flagged commands still restart windows.
- R11: `viol` is a registered pulse in the cycle after the offending command. `viol_code` is nonzero exactly when `viol` is 1. When several rules break at once, the code follows the priority 1 > 2 > 3 > 4. `viol_bank` echoes the command's `cmd_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl | input | 3 | CAS latency in cycles (3 or 4) |
| cfg_bl_sel | input | 2 | Burst length select: 0 = 2, 1 = 4, 2 or 3 = 8 |
| cfg_trcd | input | 4 | Activate-to-column delay in cycles |
| cfg_trp | input | 4 | Precharge time in cycles |
| cfg_twr | input | 4 | Write recovery in cycles |
| cfg_fast | input | 1 | Adds one cycle to the read-to-write turnaround |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Checker accepts commands (high after reset) |
| cmd_op | input | 3 | Decoded opcode |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge flag for reads and writes |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Broken rule: 1 lockout, 2 activate-to-column, 3 turnaround, 4 precharge-to-mode-load |
| viol_bank | output | 2 | Bank of the offending command |

## Verification
Directed sequences place a second command exactly one cycle before, and exactly at, each window edge. This separates an off-by-one in every counter load from a correct limit. The same read-then-write gap is sent with the fast-grade input cleared and then set, which isolates the extra turnaround cycle. Stacked commands that break several rules at once check the code priority. Back-to-back reloads check that windows restart from the newest command. Long random runs then vary the configuration and mix all opcodes across banks, and a cycle-count model in the bench predicts every pulse and code. These runs expose cross-bank leakage and rules that are confused with one another.

// File: rtl/sdr_spacing_pkg.sv
package sdr_spacing_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_PREA = 3'd5,
    OP_REF  = 3'd6,
    OP_MRS  = 3'd7
  } sdr_op_e;

  typedef enum logic [2:0] {
    VC_NONE = 3'd0,
    VC_LOCK = 3'd1,
    VC_RCD  = 3'd2,
    VC_TURN = 3'd3,
    VC_MRS  = 3'd4
  } viol_code_e;

endpackage

// File: rtl/sdr_down_timer.sv
module sdr_down_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/sdr_bank_timer.sv
module sdr_bank_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_load,
  input  logic [CNT_W-1:0] act_val,
  input  logic             lock_load,
  input  logic [CNT_W-1:0] lock_val,
  output logic             act_busy,
  output logic             lock_busy
);
  sdr_down_timer #(.W(CNT_W)) u_act (
    .clk(clk), .rst_n(rst_n), .load(act_load), .load_val(act_val), .busy(act_busy)
  );

  sdr_down_timer #(.W(CNT_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(lock_load), .load_val(lock_val), .busy(lock_busy)
  );
endmodule

// File: rtl/sdr_bus_timer.sv
module sdr_bus_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             turn_load,
  input  logic [CNT_W-1:0] turn_val,
  input  logic             pre_load,
  input  logic [CNT_W-1:0] pre_val,
  output logic             turn_busy,
  output logic             pre_busy
);
  sdr_down_timer #(.W(CNT_W)) u_turn (
    .clk(clk), .rst_n(rst_n), .load(turn_load), .load_val(turn_val), .busy(turn_busy)
  );

  sdr_down_timer #(.W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .load(pre_load), .load_val(pre_val), .busy(pre_busy)
  );
endmodule

// File: rtl/sdr_cmd_spacing_chk.sv
module sdr_cmd_spacing_chk
  import sdr_spacing_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CFG_W     = 4,
  parameter int CL_W      = 3,
  parameter int CNT_W     = 6,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CL_W-1:0]   cfg_cl,
  input  logic [1:0]        cfg_bl_sel,
  input  logic [CFG_W-1:0]  cfg_trcd,
  input  logic [CFG_W-1:0]  cfg_trp,
  input  logic [CFG_W-1:0]  cfg_twr,
  input  logic              cfg_fast,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_ap,
  output logic              viol,
  output logic [2:0]        viol_code,
  output logic [BANK_W-1:0] viol_bank
);

  function automatic logic [CNT_W-1:0] win_load(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - CNT_W'(1);
  endfunction

  logic ready_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign cmd_ready = ready_q;

  logic acc;
  logic is_act, is_rd, is_wr, is_pre, is_prea, is_ref, is_mrs;
  logic bank_cmd, glob_cmd;
  assign acc     = cmd_valid && ready_q;
  assign is_act  = acc && (cmd_op == OP_ACT);
  assign is_rd   = acc && (cmd_op == OP_RD);
  assign is_wr   = acc && (cmd_op == OP_WR);
  assign is_pre  = acc && (cmd_op == OP_PRE);
  assign is_prea = acc && (cmd_op == OP_PREA);
  assign is_ref  = acc && (cmd_op == OP_REF);
  assign is_mrs  = acc && (cmd_op == OP_MRS);
  assign bank_cmd = is_act || is_rd || is_wr || is_pre;
  assign glob_cmd = is_prea || is_ref || is_mrs;

  logic [CNT_W-1:0] half_c, cl_c, trcd_c, trp_c, twr_c, fast_c;
  always_comb begin
    unique case (cfg_bl_sel)
      2'd0:    half_c = CNT_W'(1);
      2'd1:    half_c = CNT_W'(2);
      default: half_c = CNT_W'(4);
    endcase
  end
  assign cl_c   = CNT_W'(cfg_cl);
  assign trcd_c = CNT_W'(cfg_trcd);
  assign trp_c  = CNT_W'(cfg_trp);
  assign twr_c  = CNT_W'(cfg_twr);
  assign fast_c = CNT_W'(cfg_fast);

  logic [CNT_W-1:0] turn_val, rcd_val, rda_val, wra_val, pre_val, lock_val;
  assign turn_val = win_load(cl_c + half_c + fast_c);
  assign rcd_val  = win_load(trcd_c);
  assign rda_val  = win_load(half_c + trp_c);
  assign wra_val  = win_load(half_c + CNT_W'(1) + twr_c + trp_c);
  assign pre_val  = win_load(trp_c);
  assign lock_val = is_wr ? wra_val : rda_val;

  logic [NUM_BANKS-1:0] act_busy, lock_busy;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = bank_cmd && (cmd_bank == BANK_W'(b));
    sdr_bank_timer #(.CNT_W(CNT_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_load (sel && is_act),
      .act_val  (rcd_val),
      .lock_load(sel && (is_rd || is_wr) && cmd_ap),
      .lock_val (lock_val),
      .act_busy (act_busy[b]),
      .lock_busy(lock_busy[b])
    );
  end

  logic turn_busy, pre_busy;
  sdr_bus_timer #(.CNT_W(CNT_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .turn_load(is_rd),
    .turn_val (turn_val),
    .pre_load (is_pre || is_prea),
    .pre_val  (pre_val),
    .turn_busy(turn_busy),
    .pre_busy (pre_busy)
  );

  logic lock_hit, rcd_hit, turn_hit, mrs_hit;
  assign lock_hit = (bank_cmd && lock_busy[cmd_bank]) || (glob_cmd && (|lock_busy));
  assign rcd_hit  = (is_rd || is_wr) && act_busy[cmd_bank];
  assign turn_hit = is_wr && turn_busy;
  assign mrs_hit  = is_mrs && pre_busy;

  viol_code_e code_d;
  always_comb begin
    if (lock_hit)      code_d = VC_LOCK;
    else if (rcd_hit)  code_d = VC_RCD;
    else if (turn_hit) code_d = VC_TURN;
    else if (mrs_hit)  code_d = VC_MRS;
    else               code_d = VC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= '0;
      viol_bank <= '0;
    end else begin
      viol      <= (code_d != VC_NONE);
      viol_code <= code_d;
      viol_bank <= cmd_bank;
    end
  end

endmodule

// File: rtl/sdr_spacing_chk_sva.sv
module sdr_spacing_chk_sva #(
  parameter int BANK_W = 2,
  parameter int CFG_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [CFG_W-1:0]  cfg_trcd,
  input logic              viol,
  input logic [2:0]        viol_code
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> cmd_ready); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_op == 3'd0) |=> !viol); // R2

  AST_CODE_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> (viol_code != 3'd0)); // R11

  AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> (viol_code == 3'd0)); // R11

  AST_RD_WR_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (cmd_valid && cmd_ready && cmd_op == 3'd3 && $past(cmd_valid && cmd_ready && cmd_op == 3'd2))
    |=> viol); // R3

  AST_ACT_COL_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (cmd_valid && cmd_ready && (cmd_op == 3'd2 || cmd_op == 3'd3) && cfg_trcd > 1
     && $past(cmd_valid && cmd_ready && cmd_op == 3'd1) && $past(cmd_bank) == cmd_bank)
    |=> viol); // R5
endmodule

bind sdr_cmd_spacing_chk sdr_spacing_chk_sva #(.BANK_W(BANK_W), .CFG_W(CFG_W)) u_sva (.*);

// File: tb/test_sdr_cmd_spacing_chk.sv
`timescale 1ns/1ps
module test_sdr_cmd_spacing_chk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_cl = 3'd3;
  logic [1:0] cfg_bl_sel = 2'd1;
  logic [3:0] cfg_trcd = 4'd3, cfg_trp = 4'd3, cfg_twr = 4'd2;
  logic       cfg_fast = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_ap = 1'b0;
  logic       viol;
  logic [2:0] viol_code;
  logic [1:0] viol_bank;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sdr_cmd_spacing_chk i_sdr_cmd_spacing_chk (.*);

  // model state
  int t = 0;
  int last_act[4];
  int lock_until[4];
  int last_rd, last_pre;
  bit pend = 0;
  int exp_code;
  int exp_bank;
  string pend_tag;
  string cur_tag = "R2";

  function automatic int half_len();
    return (cfg_bl_sel == 2'd0) ? 1 : (cfg_bl_sel == 2'd1) ? 2 : 4;
  endfunction

  function automatic int predict(input int op, input int b, input bit ap);
    bit any_lock = 0;
    for (int i = 0; i < 4; i++) if (t < lock_until[i]) any_lock = 1;
    if ((op >= 1 && op <= 4) && t < lock_until[b]) return 1;
    if (op >= 5 && any_lock) return 1;
    if ((op == 2 || op == 3) && (t - last_act[b]) < int'(cfg_trcd)) return 2;
    if (op == 3 && (t - last_rd) < int'(cfg_cl) + half_len() + int'(cfg_fast)) return 3;
    if (op == 7 && (t - last_pre) < int'(cfg_trp)) return 4;
    return 0;
  endfunction

  task automatic model_update(input int op, input int b, input bit ap);
    if (op == 1) last_act[b] = t;
    if (op == 2) last_rd = t;
    if (op == 2 && ap) lock_until[b] = t + half_len() + int'(cfg_trp);
    if (op == 3 && ap) lock_until[b] = t + half_len() + 1 + int'(cfg_twr) + int'(cfg_trp);
    if (op == 4 || op == 5) last_pre = t;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0d", tag, act, expv, t);
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      check(viol == (exp_code != 0), pend_tag, int'(viol), int'(exp_code != 0));
      check(int'(viol_code) == exp_code, pend_tag, int'(viol_code), exp_code);
      if (exp_code != 0) check(int'(viol_bank) == exp_bank, "R11", int'(viol_bank), exp_bank);
      check(cmd_ready == 1'b1, "R2", int'(cmd_ready), 1);
    end
  endtask

  task automatic issue(input int op, input int b, input bit ap);
    @(negedge clk);
    check_pending();
    cmd_valid = (op != 0);
    cmd_op    = 3'(op);
    cmd_bank  = 2'(b);
    cmd_ap    = ap;
    exp_code  = (op == 0) ? 0 : predict(op, b, ap);
    exp_bank  = b;
    pend_tag  = cur_tag;
    if (op != 0) model_update(op, b, ap);
    pend = 1;
    t++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(0, $urandom % 4, 1'b0);
  endtask

  task automatic settle();
    idle(40);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin last_act[i] = -1000; lock_until[i] = -1000; end
    last_rd = -1000; last_pre = -1000;

    repeat (3) @(negedge clk);
    check(viol == 1'b0, "R1", int'(viol), 0);
    check(viol_code == 3'd0, "R1", int'(viol_code), 0);
    check(cmd_ready == 1'b0, "R1", int'(cmd_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R2", int'(cmd_ready), 1);

    // R2: idle and NOP never flag
    cur_tag = "R2";
    idle(5);

    // R3: turnaround edges, N = 3+2 = 5
    cur_tag = "R3";
    issue(2, 0, 0); idle(3); issue(3, 1, 0);  // k=4 flagged
    settle();
    issue(2, 0, 0); idle(4); issue(3, 1, 0);  // k=5 accepted
    settle();

    // R4: fast grade adds a cycle
    cur_tag = "R4";
    cfg_fast = 1'b1;
    issue(2, 0, 0); idle(4); issue(3, 1, 0);  // k=5 flagged
    settle();
    issue(2, 0, 0); idle(5); issue(3, 1, 0);  // k=6 accepted
    settle();
    cfg_fast = 1'b0;

    // R5: activate to column, tRCD = 3
    cur_tag = "R5";
    issue(1, 1, 0); idle(1); issue(2, 1, 0);  // k=2 flagged
    settle();
    issue(1, 1, 0); idle(2); issue(2, 1, 0);  // k=3 accepted
    issue(1, 2, 0); issue(3, 1, 0);           // other bank, no rcd
    settle();

    // R6: read auto-precharge lockout, L = 2+3 = 5
    cur_tag = "R6";
    issue(2, 2, 1); idle(3); issue(1, 2, 0);  // k=4 flagged
    settle();
    issue(2, 2, 1); idle(4); issue(1, 2, 0);  // k=5 accepted
    settle();

    // R7: write auto-precharge lockout, L = 2+1+2+3 = 8
    cur_tag = "R7";
    issue(3, 3, 1); idle(6); issue(4, 3, 0);  // k=7 flagged
    settle();
    issue(3, 3, 1); idle(7); issue(4, 3, 0);  // k=8 accepted
    issue(3, 3, 1); issue(1, 0, 0);           // other bank free
    settle();

    // R8: global commands during lockout
    cur_tag = "R8";
    issue(3, 3, 1); idle(1); issue(6, 0, 0);
    settle();
    issue(2, 1, 1); issue(5, 0, 0);
    settle();

    // R9: precharge to mode load, tRP = 3
    cur_tag = "R9";
    issue(4, 0, 0); idle(1); issue(7, 0, 0);  // k=2 flagged
    settle();
    issue(4, 0, 0); idle(2); issue(7, 0, 0);  // k=3 accepted
    settle();

    // R10: reload from newest command
    cur_tag = "R10";
    issue(2, 0, 0); idle(2); issue(2, 1, 0); idle(3); issue(3, 2, 0); // flagged vs 2nd read
    settle();
    issue(1, 1, 0); issue(1, 1, 0); idle(1); issue(2, 1, 0);  // k=2 from 2nd act
    settle();

    // R11: stacked rules resolve by priority
    cur_tag = "R11";
    issue(1, 1, 0); issue(2, 1, 1); issue(3, 1, 0);  // lock+rcd+turn -> 1
    settle();
    issue(1, 0, 0); issue(2, 2, 0); issue(3, 0, 0);  // rcd+turn -> 2
    settle();

    // R10: random phases across configurations
    cur_tag = "R10";
    for (int ph = 0; ph < 12; ph++) begin
      settle();
      cfg_cl     = 3'(3 + $urandom % 2);
      cfg_bl_sel = 2'($urandom % 4);
      cfg_trcd   = 4'(2 + $urandom % 5);
      cfg_trp    = 4'(2 + $urandom % 5);
      cfg_twr    = 4'(1 + $urandom % 4);
      cfg_fast   = 1'($urandom % 2);
      for (int n = 0; n < 300; n++) begin
        int r = $urandom % 16;
        int op = (r < 6) ? 0 : (r < 8) ? 1 : (r < 10) ? 2 : (r < 12) ? 3 :
                 (r == 12) ? 4 : (r == 13) ? 5 : (r == 14) ? 6 : 7;
        issue(op, $urandom % 4, 1'($urandom % 2));
      end
    end
    settle();
    @(negedge clk);
    check_pending();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule